// File: doc/BRIEF.md
# Windowed Register File Mapper

This block sits between the bus of an 8-bit CPU with a 16-bit address and the rest of the memory system. The CPU addresses sixteen working registers at bus addresses 0x0000 to 0x000F. Behind them is a 264-byte register bank, and a window selector byte decides which sixteen bytes of that bank the CPU sees. The window start is the selector with its three low bits cleared. Windows therefore begin on 8-byte boundaries, and adjacent windows share half their bytes.

Every access outside the register window goes to an external memory port. Writes inside the window update the bank and are also copied to the external port, so external memory keeps a shadow of the register page. The selector can be loaded in two ways: by a bus write to address 0x001E, or by a direct load from the CPU core when an instruction changes the status byte. Read data for either source returns one cycle after the request.

Top module: `winreg_mapper`

## Requirements
- R1: A bus access at address A in 0x0000..0x000F reaches bank byte (S & 0xF8) + A[3:0], where S is the selector value before the access's clock edge. The three low bits of S have no effect on placement.
- R2: The bank holds 264 bytes. With S = 0xF8 or higher, window offsets 0x0..0xF reach bank bytes 0xF8..0x107 with no wraparound into bytes 0x00..0x0F.
- R3: A read in the window pulses neither external strobe. `cpu_rvalid` is high in the following cycle, with the bank byte on `cpu_rdata`.
- R4: A read at 0x0010 or above pulses `ext_rd` in the same cycle with `ext_addr` equal to the bus address. In the following cycle `cpu_rvalid` is high and `cpu_rdata` carries `ext_rdata`.
- R5: A write in the window updates the bank byte. In the same cycle it is copied to the external port (`ext_wr` high, same address and data).
- R6: A write at 0x0010 or above goes only to the external port and changes no bank byte.
- R7: A bus write at 0x001E loads the selector from `cpu_wdata` (visible on `win_sel` in the next cycle) and is still copied to the external port. Any cycle without a selector load leaves `win_sel` unchanged.
- R8: When `sel_load` is high, the selector takes `sel_value` in the next cycle. This load wins over a bus write to 0x001E in the same cycle.
- R9: A window access in the same cycle as a selector load uses the old window. The new window applies from the next access onward.
- R10: With `cpu_rd` and `cpu_wr` both high, only the write is performed: no `ext_rd`, and no `cpu_rvalid` in the next cycle.
- R11: Synchronous active-low reset clears every bank byte and the selector to zero and drops `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read request, one cycle |
| cpu_wr | input | 1 | CPU write request, one cycle |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read |
| sel_load | input | 1 | Direct selector load from the core |
| sel_value | input | 8 | Value for the direct selector load |
| win_sel | output | 8 | Current window selector byte |
| ext_addr | output | 16 | External port address |
| ext_wdata | output | 8 | External port write data |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_rdata | input | 8 | External read data, returned the cycle after ext_rd |

## Verification
Two things can land in the same cycle: a change of the window selector and a register access through the window. A direct selector load can also coincide with a bus write to the selector address. The bench drives `sel_load` in the same cycle as a window read and checks that the returned byte comes from the old window, then that the next read comes from the new one. It then drives `sel_load` together with a bus write to 0x001E and checks that `win_sel` takes the core's value while the bus write still reaches the external port.

// File: rtl/winreg_pkg.sv
// Package: shared types for the windowed register mapper.
// Assumes a single request per cycle on the CPU bus.
package winreg_pkg;

    // Classification of the current bus request
    typedef struct packed {
        logic win;   // address falls inside the register window
        logic sel;   // address is the selector byte
        logic rd;    // effective read (dropped when a write is present)
        logic wr;    // write
    } winreg_acc_t;

endpackage

// File: rtl/winreg_decode.sv
// Module: classifies one CPU bus request.
// Assumes the window sits at the bottom of the address space.
// A write overrides a read requested in the same cycle.
module winreg_decode
    import winreg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_SIZE = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h001E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output winreg_acc_t       acc
);

    // Purpose: decode address range and resolve read/write overlap
    always_comb begin
        acc.win = (addr < ADDR_W'(WIN_SIZE));
        acc.sel = (addr == SEL_ADDR);
        acc.wr  = wr;
        acc.rd  = rd & ~wr;
    end

endmodule

// File: rtl/winreg_selector.sv
// Module: holds the window selector byte.
// Assumes a core load and a bus load may arrive together; the core wins.
module winreg_selector #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_ld,
    input  logic [DATA_W-1:0] core_val,
    input  logic              bus_ld,
    input  logic [DATA_W-1:0] bus_val,
    output logic [DATA_W-1:0] sel_q
);

    // Purpose: register the selector with core-load priority
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (core_ld) sel_q <= core_val;
        else if (bus_ld)  sel_q <= bus_val;
    end

endmodule

// File: rtl/winreg_bank.sv
// Module: register bank built from resettable flops, one write port
// and one registered read port.
// Assumes the index is always below DEPTH.
module winreg_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 264,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // Purpose: clear on reset, load when this byte is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)                        mem[g] <= '0;
            else if (we && idx == IDX_W'(g))   mem[g] <= wdata;
        end
    end

    // Purpose: registered read of the addressed byte
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= mem[idx];
    end

endmodule

// File: rtl/winreg_mapper.sv
// Module: top of the windowed register mapper.
// Steers window accesses into the bank at the selected offset and passes
// all other accesses to the external port. Window writes are copied out.
// Assumes the external port returns read data one cycle after ext_rd.
module winreg_mapper
    import winreg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                WIN_SIZE  = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 16'h001E,
    parameter logic [DATA_W-1:0] BASE_MASK = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              sel_load,
    input  logic [DATA_W-1:0] sel_value,
    output logic [DATA_W-1:0] win_sel,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_rd,
    output logic              ext_wr,
    input  logic [DATA_W-1:0] ext_rdata
);

    localparam int WIN_AW = $clog2(WIN_SIZE);
    localparam int DEPTH  = int'(BASE_MASK) + WIN_SIZE;
    localparam int IDX_W  = $clog2(DEPTH);

    winreg_acc_t       acc;
    logic [IDX_W-1:0]  bank_idx;
    logic [DATA_W-1:0] bank_q;
    logic              rvalid_q;
    logic              from_bank_q;

    winreg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_SIZE (WIN_SIZE),
        .SEL_ADDR (SEL_ADDR)
    ) u_decode (
        .addr (cpu_addr),
        .rd   (cpu_rd),
        .wr   (cpu_wr),
        .acc  (acc)
    );

    winreg_selector #(
        .DATA_W (DATA_W)
    ) u_selector (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_ld  (sel_load),
        .core_val (sel_value),
        .bus_ld   (acc.wr & acc.sel),
        .bus_val  (cpu_wdata),
        .sel_q    (win_sel)
    );

    // Purpose: form the bank index from the current (old) selector
    always_comb begin
        bank_idx = IDX_W'(win_sel & BASE_MASK) + IDX_W'(cpu_addr[WIN_AW-1:0]);
    end

    winreg_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (acc.wr & acc.win),
        .re      (acc.rd & acc.win),
        .idx     (bank_idx),
        .wdata   (cpu_wdata),
        .rdata_q (bank_q)
    );

    // Purpose: external port drive; window writes are copied out
    always_comb begin
        ext_addr  = cpu_addr;
        ext_wdata = cpu_wdata;
        ext_wr    = acc.wr;
        ext_rd    = acc.rd & ~acc.win;
    end

    // Purpose: track read completion and its data source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q    <= 1'b0;
            from_bank_q <= 1'b0;
        end else begin
            rvalid_q    <= acc.rd;
            from_bank_q <= acc.rd & acc.win;
        end
    end

    // Purpose: select returned read data
    always_comb begin
        cpu_rvalid = rvalid_q;
        cpu_rdata  = from_bank_q ? bank_q : ext_rdata;
    end

endmodule

// File: rtl/winreg_mapper_chk.sv
// Module: property checker for winreg_mapper, attached with bind.
// Observes ports only.
module winreg_mapper_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                WIN_SIZE = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h001E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_rvalid,
    input logic              sel_load,
    input logic [DATA_W-1:0] sel_value,
    input logic [DATA_W-1:0] win_sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_wdata,
    input logic              ext_rd,
    input logic              ext_wr
);

    // R3
    win_read_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr < ADDR_W'(WIN_SIZE)) |-> (!ext_rd && !ext_wr));

    // R3
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    // R4
    ext_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr >= ADDR_W'(WIN_SIZE)) |-> (ext_rd && ext_addr == cpu_addr));

    // R5
    write_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (ext_wr && ext_addr == cpu_addr && ext_wdata == cpu_wdata));

    // R7
    bus_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == SEL_ADDR && !sel_load) |=> (win_sel == $past(cpu_wdata)));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_load && !(cpu_wr && cpu_addr == SEL_ADDR)) |=> $stable(win_sel));

    // R8
    core_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_load |=> (win_sel == $past(sel_value)));

    // R10
    rdwr_no_extrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wr) |-> !ext_rd);

    // R10
    rdwr_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wr) |=> !cpu_rvalid);

endmodule

bind winreg_mapper winreg_mapper_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_SIZE (WIN_SIZE),
    .SEL_ADDR (SEL_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_rvalid (cpu_rvalid),
    .sel_load   (sel_load),
    .sel_value  (sel_value),
    .win_sel    (win_sel),
    .ext_addr   (ext_addr),
    .ext_wdata  (ext_wdata),
    .ext_rd     (ext_rd),
    .ext_wr     (ext_wr)
);

// File: tb/test_winreg_mapper.sv
// Bench: vector table walked by one loop, then directed corner tests.
module test_winreg_mapper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd;
    logic        cpu_wr;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        sel_load;
    logic [7:0]  sel_value;
    logic [7:0]  win_sel;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_rd;
    logic        ext_wr;
    logic [7:0]  ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    winreg_mapper i_winreg_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .sel_load   (sel_load),
        .sel_value  (sel_value),
        .win_sel    (win_sel),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_rd     (ext_rd),
        .ext_wr     (ext_wr),
        .ext_rdata  (ext_rdata)
    );

    // External memory model: 256 bytes on address bits 7:0, registered read
    logic [7:0] xmem [256];
    initial for (int i = 0; i < 256; i++) xmem[i] = 8'(i) ^ 8'hC3;
    always @(posedge clk) begin
        if (ext_wr) xmem[ext_addr[7:0]] <= ext_wdata;
        if (ext_rd) ext_rdata <= xmem[ext_addr[7:0]];
    end

    task automatic check(input bit ok, input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_rd = 1'b0; cpu_wr = 1'b0; sel_load = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; sel_value = '0;
    endtask

    // op: 0 = bus write, 1 = bus read, 2 = direct selector load
    task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                          input logic [7:0] e, input int req);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; sel_value = d;
        cpu_wr = (op == 2'd0); cpu_rd = (op == 2'd1); sel_load = (op == 2'd2);
        #1;
        if (op == 2'd0)
            check(ext_wr && !ext_rd && ext_addr == a && ext_wdata == d, req, {ext_addr[7:0], ext_wdata}, {a[7:0], d});
        if (op == 2'd1)
            check(!ext_wr && ext_rd == (a >= 16'h0010), req, 16'(ext_rd), 16'(a >= 16'h0010));
        @(posedge clk);
        #1;
        idle();
        if (op == 2'd1)
            check(cpu_rvalid && cpu_rdata == e, req, {7'd0, cpu_rvalid, cpu_rdata}, {8'd1, e});
        if (op == 2'd2 || (op == 2'd0 && a == 16'h001E))
            check(win_sel == d, req, 16'(win_sel), 16'(d));
    endtask

    // {req[3:0], op[1:0], addr[15:0], data[7:0], expected[7:0]}
    localparam int NV = 25;
    localparam logic [37:0] VEC [NV] = '{
        {4'd5,  2'd0, 16'h0003, 8'h11, 8'h00},  // R5 window write, base 0x00
        {4'd3,  2'd1, 16'h0003, 8'h00, 8'h11},  // R3 window read back
        {4'd7,  2'd0, 16'h001E, 8'h08, 8'h00},  // R7 selector by bus, base 0x08
        {4'd1,  2'd1, 16'h0003, 8'h00, 8'h00},  // R1 byte 0x0B still zero
        {4'd5,  2'd0, 16'h0003, 8'h22, 8'h00},  // R5 byte 0x0B <= 0x22
        {4'd7,  2'd0, 16'h001E, 8'h00, 8'h00},  // R7 base 0x00
        {4'd1,  2'd1, 16'h000B, 8'h00, 8'h22},  // R1 overlapping window
        {4'd1,  2'd1, 16'h0003, 8'h00, 8'h11},  // R1 byte 0x03
        {4'd7,  2'd0, 16'h001E, 8'h0F, 8'h00},  // R7 selector 0x0F
        {4'd1,  2'd1, 16'h0003, 8'h00, 8'h22},  // R1 low bits ignored
        {4'd8,  2'd2, 16'h0000, 8'hFF, 8'h00},  // R8 core load, base 0xF8
        {4'd2,  2'd0, 16'h000F, 8'h77, 8'h00},  // R2 byte 0x107
        {4'd2,  2'd0, 16'h0000, 8'h66, 8'h00},  // R2 byte 0xF8
        {4'd2,  2'd1, 16'h000F, 8'h00, 8'h77},  // R2 top byte read
        {4'd8,  2'd2, 16'h0000, 8'h00, 8'h00},  // R8 base 0x00
        {4'd2,  2'd1, 16'h0007, 8'h00, 8'h00},  // R2 no wraparound into byte 0x07
        {4'd8,  2'd2, 16'h0000, 8'hF0, 8'h00},  // R8 base 0xF0
        {4'd1,  2'd1, 16'h0008, 8'h00, 8'h66},  // R1 byte 0xF8 via base 0xF0
        {4'd6,  2'd0, 16'h1234, 8'hA5, 8'h00},  // R6 external write
        {4'd4,  2'd1, 16'h1234, 8'h00, 8'hA5},  // R4 external read back
        {4'd4,  2'd1, 16'h0010, 8'h00, 8'hD3},  // R4 first address above window
        {4'd8,  2'd2, 16'h0000, 8'h00, 8'h00},  // R8 base 0x00
        {4'd6,  2'd0, 16'h0010, 8'h99, 8'h00},  // R6 write just above window
        {4'd6,  2'd1, 16'h0000, 8'h00, 8'h00},  // R6 bank byte 0x00 untouched
        {4'd4,  2'd1, 16'h0010, 8'h00, 8'h99}   // R4 external byte updated
    };

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(win_sel == 8'h00 && !cpu_rvalid && !ext_rd && !ext_wr, 11,
              {win_sel, 5'd0, cpu_rvalid, ext_rd, ext_wr}, 16'h0000);

        for (int v = 0; v < NV; v++)
            run_op(VEC[v][33:32], VEC[v][31:16], VEC[v][15:8], VEC[v][7:0], int'(VEC[v][37:34]));

        // R9: core load to 0x08 with a window read in the same cycle
        @(negedge clk);
        sel_load = 1'b1; sel_value = 8'h08; cpu_rd = 1'b1; cpu_addr = 16'h0003;
        @(posedge clk);
        #1;
        idle();
        check(cpu_rvalid && cpu_rdata == 8'h11, 9, 16'(cpu_rdata), 16'h0011);
        check(win_sel == 8'h08, 9, 16'(win_sel), 16'h0008);
        run_op(2'd1, 16'h0003, 8'h00, 8'h22, 9);  // R9 new window from next access

        // R8: core load and bus selector write together
        @(negedge clk);
        sel_load = 1'b1; sel_value = 8'h40;
        cpu_wr = 1'b1; cpu_addr = 16'h001E; cpu_wdata = 8'h80;
        #1;
        check(ext_wr && ext_wdata == 8'h80, 8, 16'(ext_wdata), 16'h0080);
        @(posedge clk);
        #1;
        idle();
        check(win_sel == 8'h40, 8, 16'(win_sel), 16'h0040);

        // R10: read and write together at window address 5, base 0x40
        @(negedge clk);
        cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h0005; cpu_wdata = 8'h5C;
        #1;
        check(!ext_rd && ext_wr, 10, {ext_rd, ext_wr}, 16'h0001);
        @(posedge clk);
        #1;
        idle();
        check(!cpu_rvalid, 10, 16'(cpu_rvalid), 16'h0000);
        run_op(2'd1, 16'h0005, 8'h00, 8'h5C, 10);  // R10 write took place

        // R11: reset clears bank and selector
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(win_sel == 8'h00 && !cpu_rvalid, 11, {win_sel, 7'd0, cpu_rvalid}, 16'h0000);
        run_op(2'd1, 16'h0003, 8'h00, 8'h00, 11);  // R11 byte 0x03 cleared
        run_op(2'd2, 16'h0000, 8'h08, 8'h00, 11);
        run_op(2'd1, 16'h0003, 8'h00, 8'h00, 11);  // R11 byte 0x0B cleared

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule